// File: doc/BRIEF.md
# Paged CSR Window Decoder

This block is the register-access front end of a controller whose configuration space is larger than the address window it decodes directly. The window is 12 bits of byte address. A control register in the direct space holds a 6-bit page number. When an access carries the marker pattern in its upper address bits, it is steered into a paged register space indexed by that page number and the low offset. All other accesses reach the directly mapped registers.

Software reaches a logical 16-bit register offset in two steps. It first writes the upper six offset bits into the page field. It then issues the access at the lower ten offset bits ORed with `0xC00`. The bus is a plain synchronous register port. A write completes in the cycle it is presented. Read data appears one cycle after the read strobe.

The paged space built here is a small array for test: `PAGES` pages of `PAGE_WORDS` words. A few direct scratch words sit at the bottom of the direct space.

Top module: `paged_csr_decoder`

## Requirements
- R1: On reset the control register, every scratch and paged word, `rdata_o` and `pio_en_o` are zero.
- R2: The control register sits at byte address `0x808`. Bits 1:0 are two independent PIO enables, and bits 18:13 are the page field. All other bits read zero and ignore writes.
- R3: An address whose bits 11:10 are both 1 reaches paged word `{page, addr[9:2]}`.
- R4: An address whose bits 11:10 are not both 1 is a direct access. It never touches the paged space.
- R5: Address bits 1:0 are ignored for both direct and paged accesses.
- R6: The following locations are unimplemented:
  - direct words other than the control register and scratch words `0..DIRECT_WORDS-1`;
  - pages at or above `PAGES`;
  - paged words at or above `PAGE_WORDS`.
  A read of an unimplemented location returns zero, a write to one is dropped, and indices do not wrap.
- R7: A new page field value governs the access in the very next cycle.
- R8: `rdata_o` is loaded one cycle after `rd_en_i` and holds while `rd_en_i` is low. A read and a write in the same cycle return the old contents.
- R9: The same low offset under different pages names distinct registers.
- R10: `pio_en_o` follows control bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after `rd_en_i` |
| pio_en_o | output | 2 | PIO direction enables from control bits 1:0 |

## Verification
The same paged offset is read after the page field changes. This separates a true page index from an ignored page field, and the read placed in the cycle right after the page write also catches a delayed page update.

Several address patterns are used:
- addresses with only bit 10 or only bit 11 set, which separate a correct two-bit marker test from a one-bit test;
- out-of-range pages and words, with neighbouring locations read back, which expose index wrapping;
- low-bit address variants, which expose byte-offset sensitivity.

Simultaneous read and write, together with idle cycles, confirm the read timing.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned LOW_W    = 10;
  localparam int unsigned PAGE_W   = 6;
  localparam int unsigned PAGE_LSB = 13;
  localparam int unsigned EN_W     = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h808;

  typedef struct packed {
    logic is_paged;
    logic is_ctrl;
    logic scr_hit;
    logic pg_hit;
  } csr_sel_t;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_pkg::*;
#(
  parameter int unsigned PAGES        = 4,
  parameter int unsigned PAGE_WORDS   = 8,
  parameter int unsigned DIRECT_WORDS = 4,
  localparam int unsigned WA_W  = ADDR_W - 2,
  localparam int unsigned PP_W  = $clog2(PAGES),
  localparam int unsigned PW_W  = $clog2(PAGE_WORDS),
  localparam int unsigned SCR_W = $clog2(DIRECT_WORDS)
) (
  input  logic [WA_W-1:0]      waddr_i,
  input  logic [PAGE_W-1:0]    page_i,
  output csr_sel_t             sel_o,
  output logic [SCR_W-1:0]     scr_idx_o,
  output logic [PP_W+PW_W-1:0] pg_idx_o
);
  logic [LOW_W-3:0] pword;
  logic             marker;

  assign pword  = waddr_i[LOW_W-3:0];
  assign marker = &waddr_i[WA_W-1:LOW_W-2];

  always_comb begin
    sel_o.is_paged = marker;
    sel_o.is_ctrl  = !marker && (waddr_i == CTRL_ADDR[ADDR_W-1:2]);
    sel_o.scr_hit  = !marker && (32'(waddr_i) < DIRECT_WORDS);
    sel_o.pg_hit   = marker && (32'(page_i) < PAGES) && (32'(pword) < PAGE_WORDS);
  end

  assign scr_idx_o = waddr_i[SCR_W-1:0];
  assign pg_idx_o  = {page_i[PP_W-1:0], pword[PW_W-1:0]};
endmodule

// File: rtl/csr_ctrl_reg.sv
module csr_ctrl_reg
  import csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [EN_W-1:0]   en_d_i,
  input  logic [PAGE_W-1:0] page_d_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [EN_W-1:0]   pio_en_o
);
  logic [EN_W-1:0]   en_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      page_q <= '0;
    end else if (wr_en_i) begin
      en_q   <= en_d_i;
      page_q <= page_d_i;
    end
  end

  always_comb begin
    ctrl_o                      = '0;
    ctrl_o[EN_W-1:0]            = en_q;
    ctrl_o[PAGE_LSB+:PAGE_W]    = page_q;
  end

  assign page_o   = page_q;
  assign pio_en_o = en_q;
endmodule

// File: rtl/csr_word_bank.sv
module csr_word_bank
  import csr_pkg::*;
#(
  parameter int unsigned WORDS = 8,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [WORDS-1:0]  we_vec;

  for (genvar g = 0; g < WORDS; g++) begin : g_we
    assign we_vec[g] = wr_en_i && (idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) if (we_vec[i]) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/paged_csr_decoder.sv
module paged_csr_decoder
  import csr_pkg::*;
#(
  parameter int unsigned PAGES        = 4,
  parameter int unsigned PAGE_WORDS   = 8,
  parameter int unsigned DIRECT_WORDS = 4,
  localparam int unsigned PP_W  = $clog2(PAGES),
  localparam int unsigned PW_W  = $clog2(PAGE_WORDS),
  localparam int unsigned SCR_W = $clog2(DIRECT_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [11:0]       addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [1:0]        pio_en_o
);
  csr_sel_t              sel;
  logic [SCR_W-1:0]      scr_idx;
  logic [PP_W+PW_W-1:0]  pg_idx;
  logic [PAGE_W-1:0]     page;
  logic [DATA_W-1:0]     ctrl_word, scr_rdata, pg_rdata, rd_val, rdata_q;
  logic                  unused_ok;

  assign unused_ok = ^{addr_i[1:0], sel.is_paged};

  csr_addr_decode #(
    .PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS), .DIRECT_WORDS(DIRECT_WORDS)
  ) i_dec (
    .waddr_i  (addr_i[ADDR_W-1:2]),
    .page_i   (page),
    .sel_o    (sel),
    .scr_idx_o(scr_idx),
    .pg_idx_o (pg_idx)
  );

  csr_ctrl_reg i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i && sel.is_ctrl),
    .en_d_i  (wdata_i[EN_W-1:0]),
    .page_d_i(wdata_i[PAGE_LSB+:PAGE_W]),
    .ctrl_o  (ctrl_word),
    .page_o  (page),
    .pio_en_o(pio_en_o)
  );

  csr_word_bank #(.WORDS(DIRECT_WORDS)) i_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i && sel.scr_hit),
    .idx_i  (scr_idx),
    .wdata_i(wdata_i),
    .rdata_o(scr_rdata)
  );

  csr_word_bank #(.WORDS(PAGES * PAGE_WORDS)) i_pg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i && sel.pg_hit),
    .idx_i  (pg_idx),
    .wdata_i(wdata_i),
    .rdata_o(pg_rdata)
  );

  always_comb begin
    rd_val = '0;
    if (sel.is_ctrl)      rd_val = ctrl_word;
    else if (sel.scr_hit) rd_val = scr_rdata;
    else if (sel.pg_hit)  rd_val = pg_rdata;
  end

  // captured before same-edge writes land
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/paged_csr_decoder_chk.sv
module paged_csr_decoder_chk
  import csr_pkg::*;
#(
  parameter int unsigned PAGES        = 4,
  parameter int unsigned DIRECT_WORDS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [11:0]       addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [31:0]       rdata_o,
  input logic [DATA_W-1:0] ctrl_i
);
  logic at_ctrl, at_paged, direct_void, page_void;

  assign at_ctrl     = (addr_i[11:2] == CTRL_ADDR[11:2]);
  assign at_paged    = (addr_i[11:10] == 2'b11);
  assign direct_void = !at_paged && !at_ctrl && (32'(addr_i[11:2]) >= DIRECT_WORDS);
  assign page_void   = at_paged && (32'(ctrl_i[PAGE_LSB+:PAGE_W]) >= PAGES);

  // R2
  ctrl_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && at_ctrl |=> rdata_o == $past(ctrl_i));

  // R2
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && at_ctrl) |=> $stable(ctrl_i));

  // R6
  direct_void_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && direct_void |=> rdata_o == '0);

  // R6
  page_void_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && page_void |=> rdata_o == '0);

  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind paged_csr_decoder paged_csr_decoder_chk #(
  .PAGES(PAGES), .DIRECT_WORDS(DIRECT_WORDS)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .rdata_o(rdata_o),
  .ctrl_i (ctrl_word)
);

// File: tb/test_paged_csr_decoder.sv
module test_paged_csr_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pio_en;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  paged_csr_decoder i_paged_csr_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .pio_en_o(pio_en)
  );

  typedef struct packed {
    logic        is_rd;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd2,  12'h808, 32'h0000_2003},  // page 1, both enables
    '{1'b1, 4'd2,  12'h808, 32'h0000_2003},  // R2
    '{1'b0, 4'd3,  12'hC04, 32'h0000_00A1},
    '{1'b1, 4'd3,  12'hC04, 32'h0000_00A1},  // R3
    '{1'b0, 4'd7,  12'h808, 32'h0000_4003},  // page 2
    '{1'b1, 4'd7,  12'hC04, 32'h0000_0000},  // R7 next cycle
    '{1'b0, 4'd3,  12'hC04, 32'h0000_00B2},
    '{1'b1, 4'd3,  12'hC04, 32'h0000_00B2},
    '{1'b0, 4'd9,  12'h808, 32'h0000_2003},
    '{1'b1, 4'd9,  12'hC04, 32'h0000_00A1},  // R9
    '{1'b1, 4'd5,  12'hC07, 32'h0000_00A1},  // R5 paged
    '{1'b1, 4'd5,  12'h80B, 32'h0000_2003},  // R5 ctrl
    '{1'b0, 4'd4,  12'h004, 32'h0000_1234},
    '{1'b1, 4'd4,  12'h004, 32'h0000_1234},  // R4
    '{1'b1, 4'd5,  12'h006, 32'h0000_1234},  // R5 direct
    '{1'b0, 4'd4,  12'h404, 32'h0000_0099},  // bit 10 only
    '{1'b1, 4'd4,  12'h404, 32'h0000_0000},
    '{1'b1, 4'd4,  12'h004, 32'h0000_1234},
    '{1'b0, 4'd4,  12'h808, 32'h0000_0003},  // page 0
    '{1'b1, 4'd4,  12'hC04, 32'h0000_0000},
    '{1'b0, 4'd2,  12'h808, 32'hFFFF_FFFF},
    '{1'b1, 4'd2,  12'h808, 32'h0007_E003},  // R2 reserved bits
    '{1'b0, 4'd6,  12'hC00, 32'h0000_0055},  // page 63: dropped
    '{1'b0, 4'd6,  12'h808, 32'h0000_6003},  // page 3
    '{1'b1, 4'd6,  12'hC00, 32'h0000_0000},  // R6 no page wrap
    '{1'b0, 4'd6,  12'hC20, 32'h0000_0077},  // word 8: dropped
    '{1'b1, 4'd6,  12'hC00, 32'h0000_0000},  // R6 no word wrap
    '{1'b1, 4'd6,  12'hC20, 32'h0000_0000},
    '{1'b1, 4'd6,  12'h800, 32'h0000_0000},  // bit 11 only
    '{1'b0, 4'd6,  12'h010, 32'h0000_00AA},
    '{1'b1, 4'd6,  12'h010, 32'h0000_0000},
    '{1'b1, 4'd6,  12'h000, 32'h0000_0000}
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rdata, exp, tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(rdata, 32'h0, "R1 rdata");
    check({30'h0, pio_en}, 32'h0, "R1 pio_en");
    rd(12'h808, 32'h0, "R1 ctrl");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) rd(VEC[i].addr, VEC[i].data, $sformatf("R%0d", VEC[i].req));
      else wr(VEC[i].addr, VEC[i].data);
    end

    // R10
    check({30'h0, pio_en}, 32'h3, "R10 both");
    wr(12'h808, 32'h0000_6001);
    check({30'h0, pio_en}, 32'h1, "R10 one");
    wr(12'h808, 32'h0000_6002);
    check({30'h0, pio_en}, 32'h2, "R10 other");

    // R8: same-cycle read and write returns old value, then holds
    addr = 12'h004; wdata = 32'h0000_5678; rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check(rdata, 32'h0000_1234, "R8 old");
    addr = 12'h808;
    repeat (3) @(negedge clk);
    check(rdata, 32'h0000_1234, "R8 hold");
    rd(12'h004, 32'h0000_5678, "R8 new");

    // R1: reset mid-run clears everything
    rst_ni = 1'b0;
    @(negedge clk);
    check(rdata, 32'h0, "R1 rdata after reset");
    check({30'h0, pio_en}, 32'h0, "R1 pio_en after reset");
    rst_ni = 1'b1;
    @(negedge clk);
    rd(12'h808, 32'h0, "R1 ctrl after reset");
    rd(12'h004, 32'h0, "R1 scratch after reset");
    wr(12'h808, 32'h0000_2000);
    rd(12'hC04, 32'h0, "R1 paged after reset");

    finish_run();
  end
endmodule